// File: doc/BRIEF.md
# Dual-Slot Edge Input Capture

This block timestamps transitions on a single external pin. It watches the pin for the edge type that the mode inputs select. On each qualifying edge it copies the value of an externally supplied free-running counter into one of two capture registers. The first qualifying edge fills slot A and the second fills slot B. After that the unit holds both values and ignores further edges until software restarts the sequence.

A one-cycle event strobe marks either the first capture or the second, chosen by a select input. This lets software take an interrupt after a single timestamp, or only after a pair such as the two edges of a pulse. The sequence restarts in two cases: when software clears the capture status, or when the mode moves from "off" to an active edge type.

The pin is asynchronous and passes through a synchronizer. The counter, the mode, the direction bit and the clear strobe are synchronous to the block clock. The block has no streamed data path: the capture registers are plain register outputs and every other pin is plain control or status, so there is no back-pressure to observe.

Top module: `dual_edge_capture`

## Requirements
- R1: `mode_i` selects the edge type: 0 captures nothing, 1 captures rising edges, 2 captures falling edges, 3 captures both edges.
- R2: Captures happen only while `dir_in_i` is 1 (pin used as input). While it is 0, edges leave both capture registers and `event_o` unchanged.
- R3: The first qualifying edge after a restart stores the counter into `cap_a_o`. The second stores it into `cap_b_o`. Later edges change neither register until a restart.
- R4: With `sel_second_i` = 0, `event_o` pulses for one cycle together with the slot A capture and stays low for the slot B capture.
- R5: With `sel_second_i` = 1, `event_o` stays low for the slot A capture and pulses for one cycle together with the slot B capture.
- R6: A cycle with `clr_i` = 1 restarts the sequence, so the next capture goes into slot A.
- R7: A cycle where `mode_i` is nonzero and the previous cycle's `mode_i` was 0 restarts the sequence. A change between two nonzero modes does not restart it.
- R8: After reset, `cap_a_o` and `cap_b_o` are 0 and `event_o` is 0.
- R9: The pin passes through a SYNC_STAGES-flop synchronizer (default 2). The capture register and `event_o` update on the third rising clock edge after the pin change, holding the `count_i` value present at that edge. After two edges they are still unchanged.
- R10: When a qualifying edge and a restart fall in the same cycle, the restart applies first and the edge is stored into slot A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous input pin being watched |
| count_i | input | CNT_W | Free-running counter value to timestamp |
| mode_i | input | 2 | Edge select: 0 off, 1 rising, 2 falling, 3 both |
| dir_in_i | input | 1 | 1 when the pin is used as an input |
| sel_second_i | input | 1 | 0: event on first capture, 1: event on second |
| clr_i | input | 1 | Capture status clear strobe, restarts the slot sequence |
| cap_a_o | output | CNT_W | First capture register |
| cap_b_o | output | CNT_W | Second capture register |
| event_o | output | 1 | One-cycle capture event strobe |

## Verification
The bench builds the block with CNT_W = 32 and SYNC_STAGES = 2. This makes the full-width counter values distinguishable in each slot and fixes the pin-to-capture latency at three clock edges. That latency lets a clear strobe be placed exactly on the capture cycle to exercise the same-cycle ordering. The two-flop depth also makes the "not yet after two edges" boundary observable at the ports.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;

  localparam int unsigned SLOTS = 2;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

  // R1
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
endmodule

// File: rtl/cap_slot_ctrl.sv
module cap_slot_ctrl #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             restart_i,
  input  logic             sel_second_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic             event_o
);
  localparam int unsigned IDX_W = $clog2(cap_pkg::SLOTS + 1);

  logic [IDX_W-1:0] idx_q, idx_eff;
  logic [CNT_W-1:0] cap_a_q, cap_b_q;
  logic             event_q;

  assign idx_eff = restart_i ? '0 : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      cap_a_q <= '0;
      cap_b_q <= '0;
      event_q <= 1'b0;
    end else if (hit_i && (idx_eff < IDX_W'(cap_pkg::SLOTS))) begin
      if (idx_eff == '0) cap_a_q <= count_i;
      else               cap_b_q <= count_i;
      idx_q   <= idx_eff + IDX_W'(1);
      event_q <= (idx_eff == IDX_W'(sel_second_i));
    end else begin
      idx_q   <= idx_eff;
      event_q <= 1'b0;
    end
  end

  assign cap_a_o = cap_a_q;
  assign cap_b_o = cap_b_q;
  assign event_o = event_q;

  // R3
  slot_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_W'(2) && !restart_i) |=> ($stable(cap_a_q) && $stable(cap_b_q)));
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(2));
  // R4
  event_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_q |-> (idx_q == ($past(sel_second_i) ? IDX_W'(2) : IDX_W'(1))));
  // R5
  event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_q |-> $past(hit_i));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       mode_i,
  input  logic             dir_in_i,
  input  logic             sel_second_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic             event_o
);
  import cap_pkg::*;

  cap_mode_e mode, mode_q;
  logic      rise, fall, qual, hit, restart;

  assign mode = cap_mode_e'(mode_i);

  cap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= CAP_OFF;
    else        mode_q <= mode;
  end

  always_comb begin
    unique case (mode)
      CAP_RISE: qual = rise;
      CAP_FALL: qual = fall;
      CAP_BOTH: qual = rise | fall;
      default:  qual = 1'b0;
    endcase
  end

  assign hit     = qual & dir_in_i;
  assign restart = clr_i | ((mode_q == CAP_OFF) && (mode != CAP_OFF));

  cap_slot_ctrl #(.CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .restart_i(restart),
    .sel_second_i(sel_second_i), .count_i(count_i),
    .cap_a_o(cap_a_o), .cap_b_o(cap_b_o), .event_o(event_o)
  );

  // R2
  dir_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_in_i |=> ($stable(cap_a_o) && $stable(cap_b_o) && !event_o));
  // R1
  mode_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0) |=> ($stable(cap_a_o) && $stable(cap_b_o) && !event_o));
  // R10
  restart_edge_slot_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && hit) |=> (cap_a_o == $past(count_i)));
endmodule

// File: tb/test_dual_edge_capture.sv
module test_dual_edge_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [31:0] cnt = '0;
  logic [1:0]  mode = 2'd0;
  logic        dir_in = 1'b1;
  logic        sel2 = 1'b0;
  logic        clr = 1'b0;
  logic [31:0] cap_a, cap_b;
  logic        ev;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dual_edge_capture #(.CNT_W(32), .SYNC_STAGES(2)) i_dual_edge_capture (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .count_i(cnt), .mode_i(mode),
    .dir_in_i(dir_in), .sel_second_i(sel2), .clr_i(clr),
    .cap_a_o(cap_a), .cap_b_o(cap_b), .event_o(ev)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // drive pin, wait the 3-edge latency, sample at the following negedge
  task automatic pin_to(logic v, logic [31:0] c);
    @(negedge clk); pin = v; cnt = c;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8", "cap_a", cap_a, 0);
    chk("R8", "cap_b", cap_b, 0);
    chk("R8", "event", {31'd0, ev}, 0);
  endtask

  task automatic t_rise_sel0();
    @(negedge clk); mode = 2'd1; sel2 = 1'b0;
    pin_to(1'b1, 32'h0000_0100);
    chk("R3", "cap_a first", cap_a, 32'h100);
    chk("R4", "event first", {31'd0, ev}, 1);
    @(negedge clk);
    chk("R4", "event one cycle", {31'd0, ev}, 0);
    pin_to(1'b0, 32'h0000_0150);
    chk("R1", "falling ignored in rise mode", cap_b, 0);
    pin_to(1'b1, 32'h0000_0200);
    chk("R3", "cap_b second", cap_b, 32'h200);
    chk("R4", "no event second", {31'd0, ev}, 0);
    pin_to(1'b0, 32'h0000_0250);
    pin_to(1'b1, 32'h0000_0300);
    chk("R3", "locked cap_a", cap_a, 32'h100);
    chk("R3", "locked cap_b", cap_b, 32'h200);
  endtask

  task automatic t_clear();
    pulse_clr();
    pin_to(1'b0, 32'h0000_0350);
    pin_to(1'b1, 32'h0000_0400);
    chk("R6", "cap_a after clear", cap_a, 32'h400);
    chk("R6", "cap_b kept", cap_b, 32'h200);
  endtask

  task automatic t_sel1();
    pulse_clr();
    @(negedge clk); sel2 = 1'b1;
    pin_to(1'b0, 32'h0000_0450);
    pin_to(1'b1, 32'h0000_0500);
    chk("R5", "cap_a", cap_a, 32'h500);
    chk("R5", "no event first", {31'd0, ev}, 0);
    pin_to(1'b0, 32'h0000_0550);
    pin_to(1'b1, 32'h0000_0600);
    chk("R5", "cap_b", cap_b, 32'h600);
    chk("R5", "event second", {31'd0, ev}, 1);
    @(negedge clk); sel2 = 1'b0;
  endtask

  task automatic t_fall_no_restart();
    // pin is high; slots full. rise->fall mode change must not restart (R7)
    @(negedge clk); mode = 2'd2;
    pin_to(1'b0, 32'h0000_0700);
    chk("R7", "nonzero mode change no restart", cap_a, 32'h500);
    pulse_clr();
    pin_to(1'b1, 32'h0000_0750);
    chk("R1", "rising ignored in fall mode", cap_a, 32'h500);
    pin_to(1'b0, 32'h0000_0800);
    chk("R1", "falling captured", cap_a, 32'h800);
  endtask

  task automatic t_both_enable();
    @(negedge clk); mode = 2'd0;
    pin_to(1'b1, 32'h0000_0850);
    chk("R1", "off mode ignores", cap_b, 32'h600);
    @(negedge clk); mode = 2'd3;
    @(negedge clk);
    pin_to(1'b0, 32'h0000_0900);
    chk("R7", "enable restarts to slot A", cap_a, 32'h900);
    pin_to(1'b1, 32'h0000_0a00);
    chk("R1", "both: rising into B", cap_b, 32'ha00);
  endtask

  task automatic t_dir_out();
    pulse_clr();
    @(negedge clk); dir_in = 1'b0;
    pin_to(1'b0, 32'h0000_0b00);
    chk("R2", "output dir cap_a", cap_a, 32'h900);
    chk("R2", "output dir event", {31'd0, ev}, 0);
    pin_to(1'b1, 32'h0000_0b50);
    chk("R2", "output dir cap_b", cap_b, 32'ha00);
    @(negedge clk); dir_in = 1'b1;
  endtask

  task automatic t_latency();
    // slots empty after earlier clear; sel2=0
    @(negedge clk); pin = 1'b0; cnt = 32'h0000_0c00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9", "not after two edges", cap_a, 32'h900);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "after third edge", cap_a, 32'h0c00);
    chk("R9", "event with capture", {31'd0, ev}, 1);
  endtask

  task automatic t_clr_same_cycle();
    pin_to(1'b1, 32'h0000_0d00);
    chk("R10", "slot B filled", cap_b, 32'h0d00);
    @(negedge clk); pin = 1'b0; cnt = 32'h0000_0e00;
    repeat (2) @(posedge clk);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R10", "edge with clear goes to A", cap_a, 32'h0e00);
    chk("R10", "B untouched", cap_b, 32'h0d00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise_sel0();
    t_clear();
    t_sel1();
    t_fall_no_restart();
    t_both_enable();
    t_dir_out();
    t_latency();
    t_clr_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule